// File: doc/BRIEF.md
# Dual 16-bit Signed Multiply-Accumulate

This datapath splits each of two 32-bit operands into a pair of signed 16-bit halves and multiplies the matching halves. It then adds or subtracts the two products. The second operand can first be rotated by 16 bits, which swaps its halves, so that the cross products are formed instead. One control bit picks between two forms. The short form produces a 32-bit result that may take an accumulator from the low accumulator word. The long form always adds a 64-bit accumulator made from the high and low words and returns a 64-bit result.

In the long form, each 32-bit product is sign-extended to 64 bits on its own before the products are combined. Because of this, a large positive sum can never come out negative. In the short form, a sticky saturation flag records any signed overflow of the 32-bit additions. The flag stays set until software clears it through a dedicated input. Every operation is registered once, and a new operation can be accepted on every cycle.

Top module: `dmac_top`

## Requirements
- R1: When `ctl_swap` is 1, the halves of `opb` are exchanged before multiplying: bits [15:0] pair with `opa[31:16]` and bits [31:16] pair with `opa[15:0]`. When `ctl_swap` is 0, low pairs with low and high pairs with high.
- R2: Product one is signed `opa[15:0]` times the signed low half of the selected `opb`, and product two is the same for the high halves. The combined value is product one minus product two when `ctl_sub` is 1, and their sum when it is 0.
- R3: When `ctl_long` is 1, each product is sign-extended to 64 bits before combining, and the signed 64-bit value {`acc_hi`,`acc_lo`} is added. Bits [63:32] of the result appear on `res_hi` and bits [31:0] on `res_lo`, wrapping modulo 2^64.
- R4: In the long form, two products of 0x40000000 that are added with a zero accumulator give `res_hi`=0x00000000 and `res_lo`=0x80000000, which is a positive result.
- R5: A long-form operation never sets `q_flag`, whether it adds or subtracts.
- R6: A short-form subtraction with `ctl_acc`=0 never sets `q_flag`.
- R7: When `ctl_long` is 0 and `ctl_sub` is 0, signed overflow of the 32-bit product sum sets `q_flag`, and `res_lo` holds the sum wrapped modulo 2^32.
- R8: When `ctl_long` is 0 and `ctl_acc` is 1, `acc_lo` is added to the wrapped product sum or difference, wrapping modulo 2^32. Signed overflow of this addition also sets `q_flag`. In the short form, `res_hi` is 0.
- R9: `q_flag` is sticky. It stays 1 until a cycle with `q_clear`=1 and no new set. When a clear and a set happen in the same cycle, it stays 1.
- R10: `out_valid` rises exactly one cycle after `in_valid` and is 0 one cycle after a cycle with `in_valid`=0. Operations on consecutive cycles each give their own result. When `in_valid` is 0, the result words hold their values.
- R11: A synchronous active-high `rst` clears `out_valid`, `q_flag`, `res_hi` and `res_lo` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opa | input | 32 | First operand, two signed halves |
| opb | input | 32 | Second operand, two signed halves |
| acc_hi | input | 32 | Accumulator upper word (long form) |
| acc_lo | input | 32 | Accumulator lower word |
| ctl_swap | input | 1 | Exchange halves of `opb` |
| ctl_sub | input | 1 | Subtract product two from product one |
| ctl_long | input | 1 | 64-bit long form |
| ctl_acc | input | 1 | Short form adds `acc_lo` |
| q_clear | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result strobe |
| res_hi | output | 32 | Result upper word |
| res_lo | output | 32 | Result lower word |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
The properties assume that the control bits and `q_clear` are valid binary levels on every clock edge, including idle cycles, because the flag logic reads `q_clear` even when `in_valid` is low. The no-set properties for the long form and the short subtraction also assume that no clear is needed to keep the flag low, so they start only from a cleared flag. The stimulus drives every input at the falling edge. It pairs directed extremes (0x8000 and 0x7FFF halves, an accumulator near the signed limits) with random operands, and it keeps the control bits at 0 or 1.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int unsigned HALF_W_DEF = 16;

    typedef struct packed {
        logic swap;
        logic sub;
        logic long_form;
        logic acc_en;
    } dmac_ctl_t;

    // signed overflow of a two's complement addition, judged from the sign bits
    function automatic logic add_ovf(input logic sa, input logic sb, input logic ss);
        return (sa == sb) && (ss != sa);
    endfunction

endpackage

// File: rtl/dmac_lanes.sv
module dmac_lanes
    import dmac_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF,
    localparam int unsigned WORD_W = 2 * HALF_W
) (
    input  logic [WORD_W-1:0]           opa,
    input  logic [WORD_W-1:0]           opb,
    input  logic                        swap,
    output logic [1:0][WORD_W-1:0]      prod
);

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic signed [HALF_W-1:0] a_half;
        logic signed [HALF_W-1:0] b_half;
        logic signed [WORD_W-1:0] p;

        assign a_half = opa[g*HALF_W +: HALF_W];
        assign b_half = swap ? opb[(1-g)*HALF_W +: HALF_W]
                             : opb[g*HALF_W +: HALF_W];
        assign p       = a_half * b_half;
        assign prod[g] = p;
    end

endmodule

// File: rtl/dmac_combine.sv
module dmac_combine
    import dmac_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF,
    localparam int unsigned WORD_W = 2 * HALF_W,
    localparam int unsigned LONG_W = 2 * WORD_W
) (
    input  logic [1:0][WORD_W-1:0] prod,
    input  dmac_ctl_t              ctl,
    input  logic [WORD_W-1:0]      acc_hi,
    input  logic [WORD_W-1:0]      acc_lo,
    output logic [LONG_W-1:0]      value,
    output logic                   q_set
);

    localparam int unsigned MSB = WORD_W - 1;

    logic [LONG_W-1:0] ext_one;
    logic [LONG_W-1:0] ext_two;
    logic [LONG_W-1:0] long_mix;
    logic [LONG_W-1:0] long_val;
    logic [WORD_W-1:0] short_mix;
    logic [WORD_W-1:0] short_acc;
    logic              mix_ovf;
    logic              acc_ovf;

    // long path: widen each product on its own, then combine
    always_comb begin
        ext_one  = {{WORD_W{prod[0][MSB]}}, prod[0]};
        ext_two  = {{WORD_W{prod[1][MSB]}}, prod[1]};
        long_mix = ctl.sub ? (ext_one - ext_two) : (ext_one + ext_two);
        long_val = long_mix + {acc_hi, acc_lo};
    end

    // short path: 32-bit arithmetic with overflow detection
    always_comb begin
        short_mix = ctl.sub ? (prod[0] - prod[1]) : (prod[0] + prod[1]);
        mix_ovf   = !ctl.sub && add_ovf(prod[0][MSB], prod[1][MSB], short_mix[MSB]);
        short_acc = short_mix + acc_lo;
        acc_ovf   = ctl.acc_en && add_ovf(short_mix[MSB], acc_lo[MSB], short_acc[MSB]);
    end

    always_comb begin
        if (ctl.long_form) begin
            value = long_val;
            q_set = 1'b0;
        end else begin
            value = {{WORD_W{1'b0}}, (ctl.acc_en ? short_acc : short_mix)};
            q_set = mix_ovf || acc_ovf;
        end
    end

endmodule

// File: rtl/dmac_qflag.sv
module dmac_qflag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clear_i,
    output logic flag_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clear_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int unsigned HALF_W = HALF_W_DEF,
    localparam int unsigned WORD_W = 2 * HALF_W,
    localparam int unsigned LONG_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [WORD_W-1:0] acc_hi,
    input  logic [WORD_W-1:0] acc_lo,
    input  logic              ctl_swap,
    input  logic              ctl_sub,
    input  logic              ctl_long,
    input  logic              ctl_acc,
    input  logic              q_clear,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo,
    output logic              q_flag
);

    dmac_ctl_t              ctl;
    logic [1:0][WORD_W-1:0] prod;
    logic [LONG_W-1:0]      value;
    logic                   q_set;

    assign ctl = '{swap: ctl_swap, sub: ctl_sub, long_form: ctl_long, acc_en: ctl_acc};

    dmac_lanes #(.HALF_W(HALF_W)) u_lanes (
        .opa  (opa),
        .opb  (opb),
        .swap (ctl.swap),
        .prod (prod)
    );

    dmac_combine #(.HALF_W(HALF_W)) u_combine (
        .prod   (prod),
        .ctl    (ctl),
        .acc_hi (acc_hi),
        .acc_lo (acc_lo),
        .value  (value),
        .q_set  (q_set)
    );

    dmac_qflag u_qflag (
        .clk     (clk),
        .rst     (rst),
        .set_i   (in_valid && q_set),
        .clear_i (q_clear),
        .flag_o  (q_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_hi    <= '0;
            res_lo    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_hi <= value[LONG_W-1:WORD_W];
                res_lo <= value[WORD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              ctl_sub,
    input logic              ctl_long,
    input logic              ctl_acc,
    input logic              q_clear,
    input logic              out_valid,
    input logic [WORD_W-1:0] res_hi,
    input logic [WORD_W-1:0] res_lo,
    input logic              q_flag
);

    p_reset_r11: assert property (@(posedge clk)
        rst |=> (!out_valid && !q_flag && res_hi == '0 && res_lo == '0));

    p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_hi) && $stable(res_lo)));

    p_long_no_q_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_long && !q_flag) |=> !q_flag);

    p_sub_no_q_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl_long && ctl_sub && !ctl_acc && !q_flag) |=> !q_flag);

    p_short_hi_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctl_long) |=> (res_hi == '0));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (q_flag && !q_clear) |=> q_flag);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (q_clear && !in_valid) |=> !q_flag);

endmodule

bind dmac_top dmac_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .ctl_sub   (ctl_sub),
    .ctl_long  (ctl_long),
    .ctl_acc   (ctl_acc),
    .q_clear   (q_clear),
    .out_valid (out_valid),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .q_flag    (q_flag)
);

// File: tb/dmac_top_test.sv
module dmac_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] opa = '0, opb = '0, acc_hi = '0, acc_lo = '0;
    logic        ctl_swap = 1'b0, ctl_sub = 1'b0, ctl_long = 1'b0, ctl_acc = 1'b0;
    logic        q_clear = 1'b0;
    logic        out_valid;
    logic [31:0] res_hi, res_lo;
    logic        q_flag;

    always #10 clk = ~clk;

    dmac_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .ctl_swap(ctl_swap), .ctl_sub(ctl_sub),
        .ctl_long(ctl_long), .ctl_acc(ctl_acc), .q_clear(q_clear),
        .out_valid(out_valid), .res_hi(res_hi), .res_lo(res_lo), .q_flag(q_flag)
    );

    typedef struct {
        logic        valid;
        logic [31:0] hi;
        logic [31:0] lo;
        logic        q;
        string       req;
    } item_t;

    item_t  sb[$];
    int     checks = 0;
    int     errors = 0;
    bit     mon_en = 0;
    bit     done = 0;
    logic   exp_q = 1'b0;
    logic [31:0] last_hi = '0, last_lo = '0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // reference arithmetic written from the requirements
    task automatic model(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] ah, input logic [31:0] al,
                         input bit swp, input bit sb_, input bit lng, input bit acc,
                         output logic [31:0] hi, output logic [31:0] lo, output bit ovf);
        logic [31:0] b2;
        longint p1, p2, s, t, r;
        b2 = swp ? {b[15:0], b[31:16]} : b;
        p1 = longint'($signed(a[15:0])) * longint'($signed(b2[15:0]));
        p2 = longint'($signed(a[31:16])) * longint'($signed(b2[31:16]));
        ovf = 0;
        if (lng) begin
            r  = (sb_ ? p1 - p2 : p1 + p2) + longint'($signed({ah, al}));
            hi = r[63:32];
            lo = r[31:0];
        end else begin
            s = sb_ ? p1 - p2 : p1 + p2;
            if (s > 64'sd2147483647 || s < -64'sd2147483648) ovf = 1;
            lo = s[31:0];
            if (acc) begin
                t = longint'($signed(lo)) + longint'($signed(al));
                if (t > 64'sd2147483647 || t < -64'sd2147483648) ovf = 1;
                lo = t[31:0];
            end
            hi = '0;
        end
    endtask

    task automatic step(input string req, input bit v,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] ah, input logic [31:0] al,
                        input bit swp, input bit sb_, input bit lng, input bit acc,
                        input bit clr);
        item_t it;
        logic [31:0] hi, lo;
        bit ovf;
        @(negedge clk);
        in_valid = v; opa = a; opb = b; acc_hi = ah; acc_lo = al;
        ctl_swap = swp; ctl_sub = sb_; ctl_long = lng; ctl_acc = acc; q_clear = clr;
        model(a, b, ah, al, swp, sb_, lng, acc, hi, lo, ovf);
        if (v) begin
            last_hi = hi;
            last_lo = lo;
        end
        exp_q  = (exp_q && !clr) || (v && ovf);
        it.valid = v; it.hi = last_hi; it.lo = last_lo; it.q = exp_q; it.req = req;
        sb.push_back(it);
        mon_en = 1;
    endtask

    task automatic idle(input string req, input bit clr);
        step(req, 0, '0, '0, '0, '0, 0, 0, 0, 0, clr);
    endtask

    // monitor: compare each cycle's outputs with the scoreboard head
    always @(posedge clk) begin
        if (mon_en) begin
            #2;
            if (sb.size() == 0) begin
                chk("R10", "scoreboard empty", 64'd1, 64'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(it.req, "out_valid", {63'd0, out_valid}, {63'd0, it.valid});
                chk(it.req, "q_flag", {63'd0, q_flag}, {63'd0, it.q});
                chk(it.req, "result", {res_hi, res_lo}, {it.hi, it.lo});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "out_valid", {63'd0, out_valid}, 64'd0);
        chk("R11", "q_flag", {63'd0, q_flag}, 64'd0);
        chk("R11", "result", {res_hi, res_lo}, 64'd0);

        // R2 short add, no overflow
        step("R2", 1, 32'h0003_0002, 32'h0005_0007, '0, '0, 0, 0, 0, 0, 0);
        // R1 swapped halves
        step("R1", 1, 32'h0003_0002, 32'h0005_0007, '0, '0, 1, 0, 0, 0, 0);
        // R2 short subtract with negative halves
        step("R2", 1, 32'hFFFD_0010, 32'h0004_FFF0, '0, '0, 0, 1, 0, 0, 0);
        // R4 corner: two 0x40000000 products added in the long form
        step("R4", 1, 32'h8000_8000, 32'h8000_8000, '0, '0, 0, 0, 1, 0, 0);
        // R3 long subtract with negative accumulator
        step("R3", 1, 32'h7FFF_8000, 32'h8000_7FFF, 32'hFFFF_FFFF, 32'h8000_0000, 0, 1, 1, 0, 0);
        // R3 long add with swap and carry across the word boundary
        step("R3", 1, 32'h1234_8765, 32'hABCD_4321, 32'h0000_0001, 32'hFFFF_FFF0, 1, 0, 1, 0, 0);
        // R5 long forms with values that would overflow short
        step("R5", 1, 32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 0, 0);
        step("R5", 1, 32'h8000_8000, 32'h7FFF_8000, '0, '0, 0, 1, 1, 0, 0);
        // R6 short subtract at its extremes
        step("R6", 1, 32'h8000_8000, 32'h7FFF_8000, '0, '0, 0, 1, 0, 0, 0);
        // R7 short add overflow sets Q and wraps
        step("R7", 1, 32'h8000_8000, 32'h8000_8000, '0, '0, 0, 0, 0, 0, 0);
        // R9 sticky across a long op and an idle cycle
        step("R9", 1, 32'h0001_0001, 32'h0001_0001, '0, '0, 0, 0, 1, 0, 0);
        idle("R9", 0);
        idle("R9", 1);
        idle("R10", 0);
        // R8 short accumulate overflow from the accumulator add
        step("R8", 1, 32'h0000_0100, 32'h0000_0100, '0, 32'h7FFF_FFF0, 0, 0, 0, 1, 0);
        idle("R9", 1);
        // R8 short accumulate without overflow, negative accumulator
        step("R8", 1, 32'h0002_0003, 32'h0004_0005, '0, 32'hFFFF_FF00, 0, 1, 0, 1, 0);
        // R9 clear and set in the same cycle keep Q
        step("R9", 1, 32'h8000_8000, 32'h8000_8000, '0, '0, 0, 0, 0, 0, 1);
        idle("R9", 1);
        // R10 back-to-back random operations
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i % 5 == 0) a = {a[31] ? 16'h8000 : 16'h7FFF, a[15] ? 16'h8000 : 16'h7FFF};
            if (i % 7 == 0) b = {16'h8000, 16'h8000};
            step("R10", ($urandom % 8) != 0, a, b, $urandom, $urandom,
                 $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                 ($urandom % 6) == 0);
        end
        idle("R10", 0);
        idle("R10", 0);
        @(negedge clk);
        mon_en = 0;
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule